// File: doc/BRIEF.md
# Kernel-Only Pipelined Loop Sequencer

This block sequences a software-pipelined loop body that has a fixed number of stages. Every iteration runs on one schedule: iteration `i` occupies stage `s` during initiation interval `i + s`, and each interval lasts `INIT_INTERVAL` unstalled cycles. There is no separate prologue path. A vector of stage-valid predicates, one bit per stage, turns off every stage that holds no iteration yet. The per-stage enables are these predicates, gated by the stall input.

The loop runs as a WHILE loop. No trip count is given; the loop ends only when a stage raises its data-dependent exit flag. The iteration that raised the flag runs to completion, together with any older iterations ahead of it. Every younger iteration, started speculatively, is discarded in the same cycle the exit is seen. There is no epilogue. When the exiting iteration leaves the last stage, the block pulses `done` and presents a binary exit code. The host uses this code to decide which live values to collect.

Top module: `kernel_loop_sequencer`

## Requirements
- R1: After reset, `stageEn` is all zero, `done` is low and `exitId` is zero.
- R2: A `start` while idle places iteration 0 in stage 0 in the next cycle. While no exit is pending, one new iteration enters stage 0 at the end of every interval of `INIT_INTERVAL` unstalled cycles. Stage `s` is enabled for iteration `i` throughout interval `i + s`.
- R3: A stage that holds no valid iteration has its enable low, and its exit flag (`exitCond` bit `s` belongs to stage `s`) is ignored. In the prologue, therefore, only stages 0..t can exit during interval t.
- R4: While `stall` is high, every stage enable is low, and the interval timer and the stage-valid vector hold their values. Exit flags are sampled only in the last unstalled cycle of an interval.
- R5: An exit raised by a valid stage at the end of an interval stops new iterations from entering stage 0.
- R6: At that exit, every stage younger (lower index) than the exiting stage is cleared at once. The exiting iteration and older iterations finish. If iteration m exits from stage k, stage s is enabled for `INIT_INTERVAL*(m+1+max(0,k-s))` unstalled cycles in total.
- R7: `done` is high for exactly one cycle. This is the cycle after the exiting iteration's final interval in the last stage ends, after `(m+NUM_STAGES)*INIT_INTERVAL` unstalled cycles counted from the start. All enables are low from then on.
- R8: `exitId` holds the index of the stage that raised the winning exit, as an unsigned binary number. It takes its new value in the `done` cycle and holds it afterwards. A `start` taken while idle clears it to zero.
- R9: If several valid stages raise an exit at the end of the same interval, the highest-indexed (oldest) stage wins.
- R10: After an exit is pending, an exit raised by a strictly older iteration replaces it, both its code and its completion time. Flags from the pending iteration's own later stages are ignored.
- R11: A `start` received while the loop is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a loop run when idle |
| stall | input | 1 | Freeze the pipeline for this cycle |
| exitCond | input | NUM_STAGES | Per-stage exit flag, bit s for stage s |
| stageEn | output | NUM_STAGES | Per-stage enable, bit s for stage s |
| done | output | 1 | One-cycle completion pulse |
| exitId | output | $clog2(NUM_STAGES) | Stage index of the winning exit |

## Verification
Some properties are checked by assertions on every cycle. With no exit pending, the valid vector must be a contiguous run of ones starting at stage 0. Enables must never be high without a valid stage, and never during a stall. A stall must freeze the valid vector. No iteration may enter after an exit. `done` must be a single pulse with an empty pipeline, and `exitId` must stay stable between updates. Other behaviour can only be shown by the bench scenarios. These cover the exact completion time under several stall patterns, the per-stage enable totals that prove younger iterations were squashed, and priority among simultaneous exits. They also cover replacement of a pending exit by an older one, flags ignored from empty stages in the prologue, and a `start` ignored during a run.

// File: rtl/loopseq_pkg.sv
package loopseq_pkg;

  // Strobes from the sequencing control to the stage datapath.
  typedef struct packed {
    logic load;     // begin a run: seed stage 0, clear exit bookkeeping
    logic advance;  // end of an unstalled interval: shift the stage vector
    logic finish;   // this advance retires the last live iteration
  } seqStrobes_t;

endpackage

// File: rtl/seq_exit_arbiter.sv
module seq_exit_arbiter #(
  parameter int NUM_STAGES = 4,
  localparam int IdW = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic [NUM_STAGES-1:0] req,
  output logic                  hit,
  output logic [IdW-1:0]        winner
);

  // Scan upward so the highest requesting stage (oldest iteration) wins.
  always_comb begin
    hit    = 1'b0;
    winner = '0;
    for (int s = 0; s < NUM_STAGES; s++) begin
      if (req[s]) begin
        hit    = 1'b1;
        winner = IdW'(s);
      end
    end
  end

endmodule

// File: rtl/seq_control.sv
module seq_control
  import loopseq_pkg::*;
#(
  parameter int INIT_INTERVAL = 2,
  localparam int CntW = (INIT_INTERVAL > 1) ? $clog2(INIT_INTERVAL) : 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        stall,
  input  logic        emptyNext,
  output seqStrobes_t strobes,
  output logic        done
);

  typedef enum logic {ST_IDLE, ST_RUN} seqState_t;

  seqState_t      state;
  logic [CntW-1:0] slotCnt;
  logic            lastSlot;

  assign lastSlot = (slotCnt == CntW'(INIT_INTERVAL - 1));

  always_comb begin
    strobes.load    = (state == ST_IDLE) && start;
    strobes.advance = (state == ST_RUN) && !stall && lastSlot;
    strobes.finish  = strobes.advance && emptyNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      slotCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobes.finish;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            slotCnt <= '0;
          end
        end
        ST_RUN: begin
          if (!stall) begin
            slotCnt <= lastSlot ? '0 : slotCnt + CntW'(1);
            if (strobes.finish) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import loopseq_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  localparam int IdW = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
  localparam int PosW = $clog2(NUM_STAGES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobes_t           strobes,
  input  logic                  stall,
  input  logic [NUM_STAGES-1:0] exitCond,
  output logic [NUM_STAGES-1:0] stageEn,
  output logic [NUM_STAGES-1:0] stageValid,
  output logic                  exiting,
  output logic                  emptyNext,
  output logic [IdW-1:0]        exitId
);

  logic [NUM_STAGES-1:0] eligible;
  logic [NUM_STAGES-1:0] keepMask;
  logic [NUM_STAGES-1:0] survivors;
  logic [NUM_STAGES-1:0] nextValid;
  logic                  hit;
  logic [IdW-1:0]        winner;
  logic [PosW-1:0]       pendPos;   // current stage of the pending exiter
  logic [IdW-1:0]        pendId;    // stage index where it raised the exit
  logic                  inject;

  // Exit qualification and squash mask, one slice per stage.
  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic olderThanPend;
    assign olderThanPend = !exiting || (PosW'(s) > pendPos);
    assign eligible[s]   = stageValid[s] && exitCond[s] && olderThanPend;
    assign keepMask[s]   = !hit || (IdW'(s) >= winner);
  end

  seq_exit_arbiter #(.NUM_STAGES(NUM_STAGES)) u_arb (
    .req   (eligible),
    .hit   (hit),
    .winner(winner)
  );

  assign inject    = !exiting && !hit;
  assign survivors = stageValid & keepMask;
  assign nextValid = (survivors << 1) | NUM_STAGES'(inject);
  assign emptyNext = (nextValid == '0);
  assign stageEn   = stageValid & {NUM_STAGES{!stall}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= '0;
      exiting    <= 1'b0;
      pendPos    <= '0;
      pendId     <= '0;
      exitId     <= '0;
    end else if (strobes.load) begin
      stageValid <= NUM_STAGES'(1);
      exiting    <= 1'b0;
      pendPos    <= '0;
      pendId     <= '0;
      exitId     <= '0;
    end else if (strobes.advance) begin
      stageValid <= nextValid;
      if (hit) begin
        exiting <= 1'b1;
        pendPos <= PosW'(winner) + PosW'(1);
        pendId  <= winner;
      end else if (exiting) begin
        pendPos <= pendPos + PosW'(1);
      end
      if (strobes.finish) exitId <= hit ? winner : pendId;
    end
  end

endmodule

// File: rtl/kernel_loop_sequencer.sv
module kernel_loop_sequencer
  import loopseq_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int INIT_INTERVAL = 2,
  localparam int IdW = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  stall,
  input  logic [NUM_STAGES-1:0] exitCond,
  output logic [NUM_STAGES-1:0] stageEn,
  output logic                  done,
  output logic [IdW-1:0]        exitId
);

  seqStrobes_t           strobes;
  logic                  emptyNext;
  logic [NUM_STAGES-1:0] stageValid;
  logic                  exiting;

  seq_control #(.INIT_INTERVAL(INIT_INTERVAL)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .stall    (stall),
    .emptyNext(emptyNext),
    .strobes  (strobes),
    .done     (done)
  );

  seq_datapath #(.NUM_STAGES(NUM_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .stall     (stall),
    .exitCond  (exitCond),
    .stageEn   (stageEn),
    .stageValid(stageValid),
    .exiting   (exiting),
    .emptyNext (emptyNext),
    .exitId    (exitId)
  );

endmodule

// File: rtl/loopseq_checker.sv
module loopseq_checker #(
  parameter int NUM_STAGES = 4,
  localparam int IdW = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  start,
  input logic                  stall,
  input logic [NUM_STAGES-1:0] stageEn,
  input logic                  done,
  input logic [IdW-1:0]        exitId,
  input logic [NUM_STAGES-1:0] stageValid,
  input logic                  exiting
);

  assert_prologue_contiguous_R3: assert property (@(posedge clk) disable iff (!rstN)
    !exiting |-> ((stageValid & (stageValid + NUM_STAGES'(1))) == '0));

  assert_enable_needs_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stageEn & ~stageValid) == '0);

  assert_stall_blocks_enables_R4: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> stageEn == '0);

  assert_stall_holds_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !start) |=> stageValid == $past(stageValid));

  assert_no_entry_after_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (exiting && !start) |=> !stageValid[0]);

  assert_done_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_pipeline_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> stageValid == '0);

  assert_exit_id_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (done || $stable(exitId)));

endmodule

bind kernel_loop_sequencer loopseq_checker #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .stall     (stall),
  .stageEn   (stageEn),
  .done      (done),
  .exitId    (exitId),
  .stageValid(stageValid),
  .exiting   (exiting)
);

// File: tb/kernel_loop_sequencer_bench.sv
module kernel_loop_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS  = 4;
  localparam int II  = 2;
  localparam int IdW = 2;

  logic          clk = 1'b0;
  logic          rstN;
  logic          start;
  logic          stall;
  logic [NS-1:0] exitCond;
  logic [NS-1:0] stageEn;
  logic          done;
  logic [IdW-1:0] exitId;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kernel_loop_sequencer #(.NUM_STAGES(NS), .INIT_INTERVAL(II)) u_kernel_loop_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .stall(stall),
    .exitCond(exitCond), .stageEn(stageEn), .done(done), .exitId(exitId)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      misses++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit stallAt(input int mode, input int c);
    case (mode)
      1:       return (c % 3) == 2;
      2:       return (c % 7) < 3;
      default: return 1'b0;
    endcase
  endfunction

  // One loop run. Exit masks are applied during whole intervals t1 and t2.
  // Expected: iteration expM wins with code expId.
  task automatic runScenario(input int t1, input int mask1, input int t2, input int mask2,
                             input int expId, input int expM, input int stallMode,
                             input bit noisyStart, input bit doCounts, input string req);
    int target;
    int enCount[NS];
    int ns;
    int stallEn;
    bit seen;
    int doneNs;
    int gotId;
    int idAtStart;
    int interval;
    int cond;
    bit stallNow;
    target = (expM + NS) * II;
    ns = 0; stallEn = 0; seen = 1'b0; doneNs = -1; gotId = -1; idAtStart = -1;
    for (int s = 0; s < NS; s++) enCount[s] = 0;

    @(posedge clk); #1;
    start = 1'b1; stall = 1'b0; exitCond = '0;
    @(posedge clk); #1;
    start = 1'b0;
    for (int c = 0; c < 600 && !seen; c++) begin
      if (c > 0) begin @(posedge clk); #1; end
      stallNow = stallAt(stallMode, c);
      interval = ns / II;
      cond = 0;
      if (interval == t1) cond = cond | mask1;
      if (interval == t2) cond = cond | mask2;
      stall    = stallNow;
      exitCond = cond[NS-1:0];
      start    = noisyStart && ((c % 2) == 0) && (ns < target);
      @(negedge clk);
      if (c == 0) idAtStart = int'(exitId);
      if (stall && stageEn != '0) stallEn++;
      for (int s = 0; s < NS; s++) enCount[s] += int'(stageEn[s]);
      if (done) begin
        seen   = 1'b1;
        doneNs = ns;
        gotId  = int'(exitId);
      end
      if (!stall) ns++;
    end

    check(idAtStart == 0, "R8", "exitId cleared by start", idAtStart, 0);
    check(stallEn == 0, "R4", "enables during stall", stallEn, 0);
    check(doneNs == target, req, "unstalled cycles to done (R7)", doneNs, target);
    check(gotId == expId, req, "exit code", gotId, expId);
    if (noisyStart)
      check(doneNs == target, "R11", "start during run ignored", doneNs, target);
    if (doCounts) begin
      for (int s = 0; s < NS; s++) begin
        int expCnt;
        expCnt = II * (expM + 1 + ((expId > s) ? (expId - s) : 0));
        check(enCount[s] == expCnt, "R2/R6", $sformatf("stage %0d enable cycles", s),
              enCount[s], expCnt);
      end
    end

    @(posedge clk); #1;
    start = 1'b0; stall = 1'b0; exitCond = '0;
    @(negedge clk);
    check(done == 1'b0, "R7", "done is one cycle", int'(done), 0);
    check(stageEn == '0, "R7", "no enables after done", int'(stageEn), 0);
    check(int'(exitId) == expId, "R8", "exitId held after done", int'(exitId), expId);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; stall = 1'b0; exitCond = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(stageEn == '0, "R1", "stageEn after reset", int'(stageEn), 0);
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);
    check(exitId == '0, "R1", "exitId after reset", int'(exitId), 0);

    // R5 / R6: single exit from every stage, several iterations and stall patterns.
    for (int k = 0; k < NS; k++)
      for (int m = 0; m < 3; m++)
        for (int sm = 0; sm < 3; sm++)
          runScenario(m + k, 1 << k, -1, 0, k, m, sm, 1'b0, 1'b1, "R5");

    // R3: all flags raised in the prologue; only valid stages may exit.
    for (int t = 0; t < NS - 1; t++)
      for (int sm = 0; sm < 3; sm++)
        runScenario(t, (1 << NS) - 1, -1, 0, t, 0, sm, 1'b0, 1'b1, "R3");

    // R9: every mask in steady state; the highest stage wins.
    for (int mask = 1; mask < (1 << NS); mask++) begin
      int w;
      w = 0;
      for (int s = 0; s < NS; s++) if (mask[s]) w = s;
      runScenario(NS - 1, mask, -1, 0, w, NS - 1 - w, mask % 3, 1'b0, 1'b1, "R9");
    end

    // R10: an older iteration overrides a pending exit; the exiter's own later flag is ignored.
    for (int sm = 0; sm < 3; sm++) begin
      runScenario(2, 1 << 1, 3, 1 << 3, 3, 0, sm, 1'b0, 1'b0, "R10");
      runScenario(2, 1 << 1, 3, 1 << 2, 1, 1, sm, 1'b0, 1'b0, "R10");
      runScenario(2, 1 << 1, 3, 3,      1, 1, sm, 1'b0, 1'b0, "R10");
    end

    // R11: start pulses during a run; a long WHILE loop.
    runScenario(5, 1 << 2, -1, 0, 2, 3, 1, 1'b1, 1'b1, "R11");
    runScenario(20, 1 << 2, -1, 0, 2, 18, 2, 1'b1, 1'b1, "R2");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule